// File: doc/BRIEF.md
# Capacitor-Voltage Sorting Selector

This block decides which cells of one converter arm are switched into the current path during each update period. It receives the number of cells that must be inserted, the measured voltage of every cell capacitor, the signed arm current and a nominal cell voltage. From these it produces an n-bit insertion mask and a count of how many cells changed state since the previous mask. Measuring the voltages and driving the gates are left to neighbouring blocks.

The selection rests on a ranking of the cells by capacitor voltage. When the arm current discharges the inserted capacitors, the most charged cells rank first. When it charges them, the least charged rank first. In the normal mode the top-ranked cells are inserted outright. That keeps the cells balanced, but small voltage differences alone can then swap cells while the arm voltage stays the same. In band mode the previous mask is kept and only the change in the required count is applied. A full re-selection happens only when some capacitor rises above the band limit, which is the nominal voltage plus one tenth of it.

A strobe starts an update. A small sequencer has three states: `ST_IDLE` waits for the strobe, `ST_SORT` runs one odd-even transposition pass per cycle for n passes, and `ST_PICK` registers the new mask. The transitions are: strobe taken (`ST_IDLE`→`ST_SORT`), last pass done (`ST_SORT`→`ST_PICK`) and mask written (`ST_PICK`→`ST_IDLE`).

Top module: `cap_sort_sel`

## Requirements
- R1: After reset, `ins_mask` is all zeros, `swap_cnt` is 0 and `upd_done` is 0.
- R2: In normal mode with a negative arm current (sign bit of `arm_i` set, discharging), the `need_cnt` cells with the highest voltages are inserted. Bit k of `ins_mask` and bits [k*VW +: VW] of `cell_v` both belong to cell k.
- R3: In normal mode with a positive arm current (charging), the `need_cnt` cells with the lowest voltages are inserted.
- R4: An arm current of exactly zero selects the same cells as a charging current.
- R5: Cells with equal voltages are ranked by index, and the lower index ranks first, in both current directions.
- R6: A `need_cnt` above NCELL inserts all cells. A `need_cnt` of 0 inserts none. Every new mask holds exactly min(`need_cnt`, NCELL) ones.
- R7: In band mode (`band_en`=1) with no cell above the limit and an unchanged count, the mask is kept as it was and `swap_cnt` is 0, even if the ranking has changed.
- R8: In band mode with no cell above the limit, a larger count inserts only the missing number of cells, taking the best-ranked bypassed ones. A smaller count bypasses only the surplus, taking the worst-ranked inserted ones. All other cells keep their state.
- R9: The band limit is `nom_v` + floor(`nom_v`/10). Any cell voltage strictly above it makes the band-mode update a full re-selection as in R2/R3. A voltage equal to the limit does not.
- R10: `swap_cnt` equals the number of cells whose state differs between the new mask and the previous one.
- R11: `upd_done` is high for exactly one cycle, NCELL+1 rising edges after the edge that samples `upd_stb`. `ins_mask` and `swap_cnt` change only in that cycle.
- R12: A strobe that arrives while an update is running is ignored. The update completes with the inputs sampled at its own strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| upd_stb | input | 1 | Starts an update period; sampled only when idle |
| need_cnt | input | CW | Required number of inserted cells |
| cell_v | input | NCELL*VW | Capacitor voltages, cell k at [k*VW +: VW] |
| arm_i | input | AW | Signed arm current; negative discharges |
| band_en | input | 1 | Selects tolerance-band mode |
| nom_v | input | VW | Nominal cell voltage |
| ins_mask | output | NCELL | Insertion mask, bit k for cell k |
| swap_cnt | output | CW | Cells that changed state in the last update |
| upd_done | output | 1 | One-cycle pulse when a new mask is written |

## Verification
The ranking is tried with distinct voltages under a negative, a positive and a zero current. The same voltage set must yield mirrored masks for the two directions, and the zero case must match the charging one. Equal-voltage sets separate correct index tie-breaking from an unstable sort, and counts of 0 and above NCELL probe the clamp. In band mode, a sequence that reorders voltages within the band, then raises and lowers the count, then places one cell exactly on the limit and one just above it, shows apart holding, incremental insertion and removal, and forced re-selection, with `swap_cnt` and the done latency compared on every update.

// File: rtl/sel_pkg.sv
package sel_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SORT = 2'd1,
        ST_PICK = 2'd2
    } sel_state_e;
endpackage

// File: rtl/sel_band_mon.sv
module sel_band_mon #(
    parameter int NCELL = 8,
    parameter int VW    = 12
) (
    input  logic [VW-1:0]       nom_v,
    input  logic [NCELL*VW-1:0] cell_v,
    output logic                over
);
    logic [VW:0] lim;

    always_comb begin
        lim  = {1'b0, nom_v} + {1'b0, nom_v / VW'(10)};
        over = 1'b0;
        for (int k = 0; k < NCELL; k++) begin
            if ({1'b0, cell_v[k*VW +: VW]} > lim) over = 1'b1;
        end
    end
endmodule

// File: rtl/sel_rank_sort.sv
module sel_rank_sort #(
    parameter int NCELL = 8,
    parameter int VW    = 12,
    parameter int IW    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                step,
    input  logic                phase,
    input  logic                dis,
    input  logic [NCELL*VW-1:0] cell_v,
    input  logic                chk_en,
    output logic [NCELL*IW-1:0] order
);
    logic [VW-1:0] kv [NCELL];
    logic [IW-1:0] ki [NCELL];
    logic [VW-1:0] nv [NCELL];
    logic [IW-1:0] ni [NCELL];
    logic          ordered;

    // a ranks before b
    function automatic logic ahead(input logic [VW-1:0] va, input logic [IW-1:0] ia,
                                   input logic [VW-1:0] vb, input logic [IW-1:0] ib,
                                   input logic d);
        if (va == vb) return ia < ib;
        return d ? (va > vb) : (va < vb);
    endfunction

    always_comb begin
        for (int k = 0; k < NCELL; k++) begin
            nv[k] = kv[k];
            ni[k] = ki[k];
        end
        for (int k = 0; k < NCELL - 1; k++) begin
            if ((k % 2) == int'(phase) && ahead(kv[k+1], ki[k+1], kv[k], ki[k], dis)) begin
                nv[k]   = kv[k+1];
                ni[k]   = ki[k+1];
                nv[k+1] = kv[k];
                ni[k+1] = ki[k];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NCELL; k++) begin
                kv[k] <= '0;
                ki[k] <= IW'(k);
            end
        end else if (load) begin
            for (int k = 0; k < NCELL; k++) begin
                kv[k] <= cell_v[k*VW +: VW];
                ki[k] <= IW'(k);
            end
        end else if (step) begin
            for (int k = 0; k < NCELL; k++) begin
                kv[k] <= nv[k];
                ki[k] <= ni[k];
            end
        end
    end

    for (genvar g = 0; g < NCELL; g++) begin : g_out
        assign order[g*IW +: IW] = ki[g];
    end

    always_comb begin
        ordered = 1'b1;
        for (int k = 0; k < NCELL - 1; k++) begin
            if (ahead(kv[k+1], ki[k+1], kv[k], ki[k], dis)) ordered = 1'b0;
        end
    end

    // R2, R3, R5
    sort_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_en |-> ordered);
endmodule

// File: rtl/sel_pick.sv
module sel_pick #(
    parameter int NCELL = 8,
    parameter int IW    = 3,
    parameter int CW    = 4
) (
    input  logic [NCELL*IW-1:0] order,
    input  logic [NCELL-1:0]    prev,
    input  logic [CW-1:0]       need,
    input  logic                keep,
    output logic [NCELL-1:0]    mask
);
    logic [CW-1:0] pc;
    logic [CW-1:0] cnt;
    logic [IW-1:0] idx;

    always_comb begin
        pc   = CW'($countones(prev));
        cnt  = '0;
        idx  = '0;
        mask = '0;
        if (!keep) begin
            for (int k = 0; k < NCELL; k++) begin
                idx = order[k*IW +: IW];
                if (cnt < need) begin
                    mask[idx] = 1'b1;
                    cnt       = cnt + 1'b1;
                end
            end
        end else if (need >= pc) begin
            mask = prev;
            for (int k = 0; k < NCELL; k++) begin
                idx = order[k*IW +: IW];
                if (!prev[idx] && (cnt < (need - pc))) begin
                    mask[idx] = 1'b1;
                    cnt       = cnt + 1'b1;
                end
            end
        end else begin
            mask = prev;
            for (int k = NCELL - 1; k >= 0; k--) begin
                idx = order[k*IW +: IW];
                if (prev[idx] && (cnt < (pc - need))) begin
                    mask[idx] = 1'b0;
                    cnt       = cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cap_sort_sel.sv
module cap_sort_sel
    import sel_pkg::*;
#(
    parameter int NCELL = 8,
    parameter int VW    = 12,
    parameter int AW    = 16,
    parameter int CW    = $clog2(NCELL + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                upd_stb,
    input  logic [CW-1:0]       need_cnt,
    input  logic [NCELL*VW-1:0] cell_v,
    input  logic [AW-1:0]       arm_i,
    input  logic                band_en,
    input  logic [VW-1:0]       nom_v,
    output logic [NCELL-1:0]    ins_mask,
    output logic [CW-1:0]       swap_cnt,
    output logic                upd_done
);
    localparam int IW = (NCELL > 1) ? $clog2(NCELL) : 1;

    sel_state_e          state, state_n;
    logic [IW-1:0]       pass_q;
    logic [CW-1:0]       need_q;
    logic                dis_q;
    logic                keep_q;
    logic [CW-1:0]       need_c;
    logic                over;
    logic [NCELL*IW-1:0] order;
    logic [NCELL-1:0]    pick_mask;

    assign need_c = (need_cnt > CW'(NCELL)) ? CW'(NCELL) : need_cnt;

    sel_band_mon #(.NCELL(NCELL), .VW(VW)) u_band (
        .nom_v  (nom_v),
        .cell_v (cell_v),
        .over   (over)
    );

    sel_rank_sort #(.NCELL(NCELL), .VW(VW), .IW(IW)) u_sort (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (state == ST_IDLE && upd_stb),
        .step   (state == ST_SORT),
        .phase  (pass_q[0]),
        .dis    (dis_q),
        .cell_v (cell_v),
        .chk_en (state == ST_PICK),
        .order  (order)
    );

    sel_pick #(.NCELL(NCELL), .IW(IW), .CW(CW)) u_pick (
        .order (order),
        .prev  (ins_mask),
        .need  (need_q),
        .keep  (keep_q),
        .mask  (pick_mask)
    );

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: if (upd_stb) state_n = ST_SORT;
            ST_SORT: if (pass_q == IW'(NCELL - 1)) state_n = ST_PICK;
            ST_PICK: state_n = ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pass_q   <= '0;
            need_q   <= '0;
            dis_q    <= 1'b0;
            keep_q   <= 1'b0;
            ins_mask <= '0;
            swap_cnt <= '0;
            upd_done <= 1'b0;
        end else begin
            upd_done <= 1'b0;
            unique case (state)
                ST_IDLE: if (upd_stb) begin
                    need_q <= need_c;
                    dis_q  <= arm_i[AW-1];
                    keep_q <= band_en & ~over;
                    pass_q <= '0;
                end
                ST_SORT: pass_q <= pass_q + 1'b1;
                ST_PICK: begin
                    ins_mask <= pick_mask;
                    swap_cnt <= CW'($countones(pick_mask ^ ins_mask));
                    upd_done <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // R6
    mask_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done |-> ($countones(ins_mask) == int'(need_q)));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done |=> !upd_done);

    // R11
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_PICK) |=> ($stable(ins_mask) && $stable(swap_cnt)));

    // R12
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> $stable(need_q));

    // R10
    swap_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done |-> (int'(swap_cnt) == $countones(ins_mask ^ $past(ins_mask))));
endmodule

// File: tb/sim_cap_sort_sel.sv
module sim_cap_sort_sel;
    localparam int N  = 8;
    localparam int VW = 12;
    localparam int AW = 16;
    localparam int CW = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              upd_stb = 1'b0;
    logic [CW-1:0]     need_cnt = '0;
    logic [N*VW-1:0]   cell_v = '0;
    logic [AW-1:0]     arm_i = '0;
    logic              band_en = 1'b0;
    logic [VW-1:0]     nom_v = 12'd1000;
    logic [N-1:0]      ins_mask;
    logic [CW-1:0]     swap_cnt;
    logic              upd_done;

    int checks = 0;
    int fails  = 0;
    int vv [N];
    logic [N-1:0] m_prev = '0;

    always #2.5 clk = ~clk;

    cap_sort_sel #(.NCELL(N), .VW(VW), .AW(AW), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .upd_stb(upd_stb), .need_cnt(need_cnt),
        .cell_v(cell_v), .arm_i(arm_i), .band_en(band_en), .nom_v(nom_v),
        .ins_mask(ins_mask), .swap_cnt(swap_cnt), .upd_done(upd_done)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit pref(int vj, int j, int vi, int i, bit dis);
        if (vj == vi) return j < i;
        return dis ? (vj > vi) : (vj < vi);
    endfunction

    function automatic logic [N-1:0] model(int need, bit dis, bit band, logic [N-1:0] prev);
        int rk [N];
        int nc, pc, lim, cnt;
        bit viol;
        logic [N-1:0] m;
        nc   = (need > N) ? N : need;
        lim  = int'(nom_v) + int'(nom_v) / 10;
        viol = 0;
        for (int i = 0; i < N; i++) begin
            rk[i] = 0;
            if (vv[i] > lim) viol = 1;
            for (int j = 0; j < N; j++)
                if (j != i && pref(vv[j], j, vv[i], i, dis)) rk[i]++;
        end
        m = '0;
        if (!band || viol) begin
            for (int i = 0; i < N; i++) m[i] = (rk[i] < nc);
        end else begin
            m   = prev;
            pc  = $countones(prev);
            cnt = 0;
            if (nc >= pc) begin
                for (int r = 0; r < N; r++)
                    for (int i = 0; i < N; i++)
                        if (rk[i] == r && !prev[i] && cnt < nc - pc) begin
                            m[i] = 1'b1; cnt++;
                        end
            end else begin
                for (int r = N - 1; r >= 0; r--)
                    for (int i = 0; i < N; i++)
                        if (rk[i] == r && prev[i] && cnt < pc - nc) begin
                            m[i] = 1'b0; cnt++;
                        end
            end
        end
        return m;
    endfunction

    task automatic set_v(input int a0, a1, a2, a3, a4, a5, a6, a7);
        vv[0] = a0; vv[1] = a1; vv[2] = a2; vv[3] = a3;
        vv[4] = a4; vv[5] = a5; vv[6] = a6; vv[7] = a7;
    endtask

    // one update: drive, wait, check mask (tag), swap count (R10), latency (R11)
    task automatic run(input string tag, input int need, input int cur, input bit band,
                       input bit poke, output logic [N-1:0] got);
        logic [N-1:0] exp;
        int lat;
        exp = model(need, cur < 0, band, m_prev);
        @(negedge clk);
        for (int k = 0; k < N; k++) cell_v[k*VW +: VW] = VW'(vv[k]);
        need_cnt = CW'(need);
        arm_i    = AW'(cur);
        band_en  = band;
        upd_stb  = 1'b1;
        @(negedge clk);
        upd_stb = 1'b0;
        lat = 0;
        while (!upd_done && lat < 40) begin
            @(negedge clk);
            lat++;
            if (poke && lat == 2) begin
                upd_stb  = 1'b1;
                need_cnt = CW'((need + 3) % 9);
                arm_i    = AW'(-cur - 1);
                for (int k = 0; k < N; k++) cell_v[k*VW +: VW] = VW'(1090 - 7 * k);
            end
            if (poke && lat == 3) upd_stb = 1'b0;
        end
        chk({tag, " mask"}, int'(ins_mask), int'(exp));
        chk("R10 swap count", int'(swap_cnt), $countones(exp ^ m_prev));
        chk("R11 done latency", lat, N + 1);
        got = ins_mask;
        m_prev = exp;
        @(negedge clk);
        chk("R11 done drops", int'(upd_done), 0);
    endtask

    task automatic t_reset();
        chk("R1 reset mask", int'(ins_mask), 0);
        chk("R1 reset swap", int'(swap_cnt), 0);
        chk("R1 reset done", int'(upd_done), 0);
    endtask

    task automatic t_discharge();
        logic [N-1:0] g;
        set_v(1010, 990, 1050, 980, 1020, 1000, 995, 1030);
        run("R2 discharge n3", 3, -50, 0, 0, g);
        chk("R2 discharge literal", int'(g), 'h94);
        set_v(700, 900, 800, 1000, 600, 950, 850, 750);
        run("R2 discharge n5", 5, -1, 0, 0, g);
    endtask

    task automatic t_charge();
        logic [N-1:0] g;
        set_v(1010, 990, 1050, 980, 1020, 1000, 995, 1030);
        run("R3 charge n3", 3, 40, 0, 0, g);
        chk("R3 charge literal", int'(g), 'h4A);
    endtask

    task automatic t_zero();
        logic [N-1:0] g;
        set_v(1010, 990, 1050, 980, 1020, 1000, 995, 1030);
        run("R4 zero current", 2, 0, 0, 0, g);
        chk("R4 zero acts as charge", int'(g), 'h0A);
    endtask

    task automatic t_ties();
        logic [N-1:0] g;
        set_v(1000, 1000, 1000, 1000, 1000, 1000, 1000, 1000);
        run("R5 ties discharge", 3, -20, 0, 0, g);
        chk("R5 ties discharge literal", int'(g), 'h07);
        run("R5 ties charge", 3, 20, 0, 0, g);
        chk("R5 ties charge literal", int'(g), 'h07);
        set_v(900, 1000, 900, 1000, 900, 1000, 900, 1000);
        run("R5 partial ties", 2, -20, 0, 0, g);
        chk("R5 partial ties literal", int'(g), 'h0A);
    endtask

    task automatic t_clamp();
        logic [N-1:0] g;
        set_v(1010, 990, 1050, 980, 1020, 1000, 995, 1030);
        run("R6 over count", 12, -5, 0, 0, g);
        chk("R6 all inserted", int'(g), 'hFF);
        run("R6 zero count", 0, -5, 0, 0, g);
        chk("R6 none inserted", int'(g), 0);
    endtask

    task automatic t_band();
        logic [N-1:0] g, h;
        set_v(1010, 990, 1050, 980, 1020, 1000, 995, 1030);
        run("R8 band grow from empty", 3, -30, 1, 0, g);
        set_v(1060, 1070, 1000, 1080, 990, 1000, 995, 985);
        run("R7 band hold", 3, -30, 1, 0, h);
        chk("R7 mask unchanged", int'(h), int'(g));
        chk("R7 no swaps", int'(swap_cnt), 0);
        run("R8 band grow", 5, -30, 1, 0, h);
        run("R8 band shrink", 2, -30, 1, 0, h);
        run("R8 band shrink charging", 1, 30, 1, 0, h);
        set_v(1100, 1070, 1000, 1080, 990, 1000, 995, 985);
        run("R9 at limit holds", 1, -30, 1, 0, g);
        chk("R9 at limit no swap", int'(swap_cnt), 0);
        set_v(1101, 1070, 1000, 1080, 990, 1000, 995, 985);
        run("R9 above limit reselects", 4, 30, 1, 0, g);
        chk("R9 reselect literal", int'(g), 'hD4);
    endtask

    task automatic t_busy();
        logic [N-1:0] g;
        set_v(1010, 990, 1050, 980, 1020, 1000, 995, 1030);
        run("R12 strobe while busy", 4, -10, 0, 1, g);
        chk("R12 literal", int'(g), 'h95);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_discharge();
        t_charge();
        t_zero();
        t_ties();
        t_clamp();
        t_band();
        t_busy();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule